// File: doc/BRIEF.md
# Performance Event Counter Map

This block records which programmable performance counter is currently tied to each supported hardware event. Software-style writes carry a counter number and an event selector value. The block checks the counter number against a configured mask of available counters. It then adds a mapping, leaves the table as it is, or removes mappings. A write whose value is zero clears every mapping that targets the written counter.

A lookup port takes a 20-bit event index and returns a hit flag and the counter that holds the event. A second query port reports whether a given counter tracks core cycles or retired instructions. Counters 0 and 2 are permanently tied to those two events. Any other counter answers true only while it is the mapped target of the matching event.

The table has one entry per supported event. Lookups and queries are combinational, and table updates take effect at the next rising clock edge.

Top module: `pmu_evtmap`

## Requirements
- R1: After reset no event is mapped, so a lookup of any supported event returns a miss.
- R2: A write of a supported event to a valid counter raises no error, and from the next clock edge a lookup of that event hits and returns that counter.
- R3: A write to a counter below 3, at or above NUM_CTRS, or whose bit in the availability mask is clear raises the write error flag in the same cycle and leaves the table unchanged.
- R4: The supported event indices are 0x00001 (cycles), 0x00002 (instructions), 0x10019, 0x1001B and 0x10021. In each index, bits [19:16] hold the type and bits [15:0] hold the code. A nonzero write value whose event index is anything else raises the write error flag and changes no mapping.
- R5: A write of value zero to a valid counter raises no error and removes every mapping that targets that counter, on the next clock edge. Mappings to other counters are kept.
- R6: A write of an event that is already mapped, to any valid counter, raises no error and leaves the existing mapping unchanged.
- R7: A query of counter 0 reports cycles and not instructions. A query of counter 2 reports instructions and not cycles.
- R8: A query of any other counter reports cycles only while that counter is the mapped target of event 0x00001. It reports instructions only while that counter is the mapped target of event 0x00002.
- R9: The configuration error output is high when any of mask bits 0 to 2 is set, or when the mask population count exceeds NUM_CTRS minus 3.
- R10: The event index is taken from the low 20 bits of the write value. Higher value bits do not affect which event is mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avail_mask | input | NUM_CTRS | One bit per counter that may be mapped |
| cfg_err | output | 1 | The availability mask is illegal |
| wr_en | input | 1 | Write strobe, one operation per cycle |
| wr_ctr | input | IDX_W | Counter number of the write |
| wr_val | input | VAL_W | Event selector value; zero requests removal |
| wr_err | output | 1 | The current write is rejected |
| lk_evt | input | 20 | Event index to look up |
| lk_hit | output | 1 | The looked-up event is mapped |
| lk_ctr | output | IDX_W | Counter holding the looked-up event, zero on a miss |
| q_ctr | input | IDX_W | Counter number to query |
| q_cyc | output | 1 | The queried counter tracks cycles |
| q_ins | output | 1 | The queried counter tracks instructions |

## Verification
The bound checker watches several rules on every cycle:
- a write to counters 0 to 2 is flagged;
- a flagged write leaves every table entry untouched;
- a zero write leaves no entry pointing at its counter;
- fixed counters 0 and 2 answer their queries correctly;
- a lookup hit never names a counter outside 3 to NUM_CTRS-1;
- the low mask bits raise the configuration error.

The following only the bench's scenarios can show:
- that the right counter is returned after an insert;
- that duplicates and unsupported codes leave earlier mappings in place;
- that upper value bits are ignored;
- that removal spares mappings held by other counters.

// File: rtl/pmu_evtmap_pkg.sv
package pmu_evtmap_pkg;

  localparam int EVT_W   = 20;
  localparam int NUM_EVT = 5;

  typedef logic [EVT_W-1:0] evt_t;

  // Slot order matters: slot 0 is the cycle event, slot 1 the instruction event.
  localparam evt_t EVT_TABLE [NUM_EVT] = '{
    20'h00001, 20'h00002, 20'h10019, 20'h1001B, 20'h10021
  };

  localparam int SLOT_CYC = 0;
  localparam int SLOT_INS = 1;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_INSERT = 2'd1,
    OP_REMOVE = 2'd2
  } map_op_e;

endpackage

// File: rtl/pmu_ctr_check.sv
module pmu_ctr_check #(
  parameter int NUM_CTRS = 32,
  parameter int IDX_W    = 6
) (
  input  logic [NUM_CTRS-1:0] avail_mask,
  input  logic [IDX_W-1:0]    ctr,
  output logic                ctr_ok,
  output logic                cfg_err
);

  localparam int CNT_W = $clog2(NUM_CTRS + 1);
  localparam int MAX_PROG = NUM_CTRS - 3;

  logic [CNT_W-1:0] pop_cnt;

  always_comb begin
    ctr_ok = 1'b0;
    for (int i = 3; i < NUM_CTRS; i++) begin
      if (ctr == IDX_W'(i) && avail_mask[i]) begin
        ctr_ok = 1'b1;
      end
    end
  end

  always_comb begin
    pop_cnt = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      pop_cnt = pop_cnt + CNT_W'(avail_mask[i]);
    end
  end

  assign cfg_err = (|avail_mask[2:0]) || (pop_cnt > CNT_W'(MAX_PROG));

endmodule

// File: rtl/pmu_evt_decode.sv
module pmu_evt_decode
  import pmu_evtmap_pkg::*;
(
  input  evt_t               evt,
  output logic [NUM_EVT-1:0] sel_oh,
  output logic               known
);

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cmp
    assign sel_oh[g] = (evt == EVT_TABLE[g]);
  end

  assign known = |sel_oh;

endmodule

// File: rtl/pmu_map_slot.sv
module pmu_map_slot #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic             rm_en,
  input  logic [IDX_W-1:0] wr_ctr,
  output logic             vld,
  output logic [IDX_W-1:0] ctr
);

  logic             vld_q, vld_d;
  logic [IDX_W-1:0] ctr_q, ctr_d;
  logic             ce;

  assign ce = ins_en | rm_en;

  always_comb begin
    vld_d = vld_q;
    ctr_d = ctr_q;
    if (ins_en && !vld_q) begin
      vld_d = 1'b1;
      ctr_d = wr_ctr;
    end else if (rm_en && vld_q && (ctr_q == wr_ctr)) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ctr_q <= '0;
    end else if (ce) begin
      vld_q <= vld_d;
      ctr_q <= ctr_d;
    end
  end

  assign vld = vld_q;
  assign ctr = ctr_q;

endmodule

// File: rtl/pmu_evtmap.sv
module pmu_evtmap
  import pmu_evtmap_pkg::*;
#(
  parameter int NUM_CTRS = 32,
  parameter int VAL_W    = 64,
  localparam int IDX_W   = $clog2(NUM_CTRS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CTRS-1:0] avail_mask,
  output logic                cfg_err,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_ctr,
  input  logic [VAL_W-1:0]    wr_val,
  output logic                wr_err,
  input  logic [EVT_W-1:0]    lk_evt,
  output logic                lk_hit,
  output logic [IDX_W-1:0]    lk_ctr,
  input  logic [IDX_W-1:0]    q_ctr,
  output logic                q_cyc,
  output logic                q_ins
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  logic               ctr_ok;
  logic [NUM_EVT-1:0] wr_sel;
  logic               wr_known;
  logic [NUM_EVT-1:0] lk_sel;
  logic               lk_known;
  logic               val_zero;
  map_op_e            op;

  logic [NUM_EVT-1:0]            slot_vld;
  logic [NUM_EVT-1:0][IDX_W-1:0] slot_ctr;

  pmu_ctr_check #(
    .NUM_CTRS (NUM_CTRS),
    .IDX_W    (IDX_W)
  ) ctr_check_i (
    .avail_mask (avail_mask),
    .ctr        (wr_ctr),
    .ctr_ok     (ctr_ok),
    .cfg_err    (cfg_err)
  );

  pmu_evt_decode wr_dec_i (
    .evt    (wr_val[EVT_W-1:0]),
    .sel_oh (wr_sel),
    .known  (wr_known)
  );

  pmu_evt_decode lk_dec_i (
    .evt    (lk_evt),
    .sel_oh (lk_sel),
    .known  (lk_known)
  );

  assign val_zero = (wr_val == '0);

  always_comb begin
    op = OP_NONE;
    if (wr_en && ctr_ok) begin
      if (val_zero) begin
        op = OP_REMOVE;
      end else if (wr_known && !(|(wr_sel & slot_vld))) begin
        op = OP_INSERT;
      end
    end
  end

  assign wr_err = wr_en && (!ctr_ok || (!val_zero && !wr_known));

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_slot
    pmu_map_slot #(
      .IDX_W (IDX_W)
    ) slot_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .ins_en (op == OP_INSERT && wr_sel[g]),
      .rm_en  (op == OP_REMOVE),
      .wr_ctr (wr_ctr),
      .vld    (slot_vld[g]),
      .ctr    (slot_ctr[g])
    );
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ctr = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (lk_known && lk_sel[i] && slot_vld[i]) begin
        lk_hit = 1'b1;
        lk_ctr = lk_ctr | slot_ctr[i];
      end
    end
  end

  assign q_cyc = (q_ctr == IDX_W'(0)) ||
                 (slot_vld[SLOT_CYC] && slot_ctr[SLOT_CYC] == q_ctr);
  assign q_ins = (q_ctr == IDX_W'(2)) ||
                 (slot_vld[SLOT_INS] && slot_ctr[SLOT_INS] == q_ctr);

endmodule

// File: rtl/pmu_evtmap_chk.sv
module pmu_evtmap_chk
  import pmu_evtmap_pkg::*;
#(
  parameter int NUM_CTRS = 32,
  parameter int VAL_W    = 64,
  localparam int IDX_W   = $clog2(NUM_CTRS) + 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CTRS-1:0]           avail_mask,
  input logic                          cfg_err,
  input logic                          wr_en,
  input logic [IDX_W-1:0]              wr_ctr,
  input logic [VAL_W-1:0]              wr_val,
  input logic                          wr_err,
  input logic                          lk_hit,
  input logic [IDX_W-1:0]              lk_ctr,
  input logic [IDX_W-1:0]              q_ctr,
  input logic                          q_cyc,
  input logic                          q_ins,
  input logic [NUM_EVT-1:0]            slot_vld,
  input logic [NUM_EVT-1:0][IDX_W-1:0] slot_ctr
);

  logic             rm_prev_q;
  logic [IDX_W-1:0] rm_ctr_q;
  logic             rm_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rm_prev_q <= 1'b0;
      rm_ctr_q  <= '0;
    end else begin
      rm_prev_q <= wr_en && (wr_val == '0) && !wr_err;
      rm_ctr_q  <= wr_ctr;
    end
  end

  always_comb begin
    rm_left = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (slot_vld[i] && slot_ctr[i] == rm_ctr_q) begin
        rm_left = 1'b1;
      end
    end
  end

  a_r3_low_ctr_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_ctr < IDX_W'(3)) |-> wr_err);

  a_r3_rejected_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_err |=> $stable(slot_vld) && $stable(slot_ctr));

  a_r5_remove_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rm_prev_q |-> !rm_left);

  a_r7_ctr0_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ctr == IDX_W'(0)) |-> q_cyc && !q_ins);

  a_r7_ctr2_instr: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ctr == IDX_W'(2)) |-> q_ins && !q_cyc);

  a_r2_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_ctr >= IDX_W'(3)) && (lk_ctr < IDX_W'(NUM_CTRS)));

  a_r9_low_bits_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (|avail_mask[2:0]) |-> cfg_err);

endmodule

bind pmu_evtmap pmu_evtmap_chk #(
  .NUM_CTRS (NUM_CTRS),
  .VAL_W    (VAL_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .avail_mask (avail_mask),
  .cfg_err    (cfg_err),
  .wr_en      (wr_en),
  .wr_ctr     (wr_ctr),
  .wr_val     (wr_val),
  .wr_err     (wr_err),
  .lk_hit     (lk_hit),
  .lk_ctr     (lk_ctr),
  .q_ctr      (q_ctr),
  .q_cyc      (q_cyc),
  .q_ins      (q_ins),
  .slot_vld   (slot_vld),
  .slot_ctr   (slot_ctr)
);

// File: tb/pmu_evtmap_tb_top.sv
module pmu_evtmap_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTRS   = 32;
  localparam int VAL_W      = 64;
  localparam int IDX_W      = $clog2(NUM_CTRS) + 1;

  typedef struct {
    int             kind;   // 0 write error, 1 lookup, 2 query, 3 config
    string          tag;
    logic           b0;
    logic           b1;
    logic [IDX_W-1:0] c;
  } exp_t;

  logic                clk;
  logic                rst_n;
  logic [NUM_CTRS-1:0] avail_mask;
  logic                cfg_err;
  logic                wr_en;
  logic [IDX_W-1:0]    wr_ctr;
  logic [VAL_W-1:0]    wr_val;
  logic                wr_err;
  logic [19:0]         lk_evt;
  logic                lk_hit;
  logic [IDX_W-1:0]    lk_ctr;
  logic [IDX_W-1:0]    q_ctr;
  logic                q_cyc;
  logic                q_ins;

  int   total = 0;
  int   bad   = 0;
  exp_t exp_q[$];

  pmu_evtmap #(
    .NUM_CTRS (NUM_CTRS),
    .VAL_W    (VAL_W)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .avail_mask (avail_mask),
    .cfg_err    (cfg_err),
    .wr_en      (wr_en),
    .wr_ctr     (wr_ctr),
    .wr_val     (wr_val),
    .wr_err     (wr_err),
    .lk_evt     (lk_evt),
    .lk_hit     (lk_hit),
    .lk_ctr     (lk_ctr),
    .q_ctr      (q_ctr),
    .q_cyc      (q_cyc),
    .q_ins      (q_ins)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void push(int kind, string tag, logic b0, logic b1,
                               logic [IDX_W-1:0] c);
    exp_t e;
    e.kind = kind; e.tag = tag; e.b0 = b0; e.b1 = b1; e.c = c;
    exp_q.push_back(e);
  endfunction

  task automatic do_wr(input int ctr, input logic [VAL_W-1:0] val,
                       input logic exp_err, input string tag);
    @(negedge clk);
    wr_en  = 1'b1;
    wr_ctr = IDX_W'(ctr);
    wr_val = val;
    push(0, tag, exp_err, 1'b0, '0);
  endtask

  task automatic do_lk(input logic [19:0] evt, input logic exp_hit,
                       input int exp_ctr, input string tag);
    @(negedge clk);
    wr_en  = 1'b0;
    lk_evt = evt;
    push(1, tag, exp_hit, 1'b0, IDX_W'(exp_ctr));
  endtask

  task automatic do_q(input int ctr, input logic exp_cyc, input logic exp_ins,
                      input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    q_ctr = IDX_W'(ctr);
    push(2, tag, exp_cyc, exp_ins, '0);
  endtask

  task automatic do_cfg(input logic [NUM_CTRS-1:0] mask, input logic exp_bad,
                        input string tag);
    @(negedge clk);
    wr_en      = 1'b0;
    avail_mask = mask;
    push(3, tag, exp_bad, 1'b0, '0);
  endtask

  // Monitor: compares queued expectations a quarter period after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        case (e.kind)
          0: if (wr_err !== e.b0) begin
               bad++;
               $display("FAIL %s: wr_err=%b expected %b", e.tag, wr_err, e.b0);
             end
          1: if (lk_hit !== e.b0 || (e.b0 && lk_ctr !== e.c)) begin
               bad++;
               $display("FAIL %s: hit=%b ctr=%0d expected hit=%b ctr=%0d",
                        e.tag, lk_hit, lk_ctr, e.b0, e.c);
             end
          2: if (q_cyc !== e.b0 || q_ins !== e.b1) begin
               bad++;
               $display("FAIL %s: cyc=%b ins=%b expected cyc=%b ins=%b",
                        e.tag, q_cyc, q_ins, e.b0, e.b1);
             end
          default: if (cfg_err !== e.b0) begin
               bad++;
               $display("FAIL %s: cfg_err=%b expected %b", e.tag, cfg_err, e.b0);
             end
        endcase
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    avail_mask = 32'h0000_07F8;   // counters 3..10 available
    wr_en      = 1'b0;
    wr_ctr     = '0;
    wr_val     = '0;
    lk_evt     = '0;
    q_ctr      = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: empty after reset
    do_lk(20'h00001, 1'b0, 0, "R1 cycles miss after reset");
    do_lk(20'h10021, 1'b0, 0, "R1 itlb miss after reset");
    do_cfg(32'h0000_07F8, 1'b0, "R9 legal mask");

    // R2 / R8: inserts
    do_wr(5, 64'h1, 1'b0, "R2 map cycles to 5");
    do_lk(20'h00001, 1'b1, 5, "R2 cycles hit on 5");
    do_q(5, 1'b1, 1'b0, "R8 counter 5 tracks cycles");
    do_wr(6, 64'h2, 1'b0, "R2 map instructions to 6");
    do_q(6, 1'b0, 1'b1, "R8 counter 6 tracks instructions");
    do_q(9, 1'b0, 1'b0, "R8 unmapped counter 9");
    do_wr(7, 64'h10019, 1'b0, "R2 map dtlb read miss to 7");
    do_wr(7, 64'h1001B, 1'b0, "R2 map dtlb write miss to 7");
    do_lk(20'h10019, 1'b1, 7, "R2 dtlb read on 7");
    do_lk(20'h1001B, 1'b1, 7, "R2 dtlb write on 7");

    // R6: duplicate
    do_wr(8, 64'h1, 1'b0, "R6 duplicate cycles write");
    do_lk(20'h00001, 1'b1, 5, "R6 cycles stays on 5");
    do_q(8, 1'b0, 1'b0, "R6 counter 8 not cycles");

    // R3: invalid counters
    do_wr(2, 64'h10021, 1'b1, "R3 counter 2 rejected");
    do_wr(12, 64'h10021, 1'b1, "R3 counter not in mask rejected");
    do_wr(33, 64'h10021, 1'b1, "R3 counter beyond range rejected");
    do_lk(20'h10021, 1'b0, 0, "R3 itlb still unmapped");

    // R4: unsupported codes
    do_wr(8, 64'h10020, 1'b1, "R4 code 0x10020 rejected");
    do_wr(8, 64'h3, 1'b1, "R4 code 0x3 rejected");
    do_lk(20'h10020, 1'b0, 0, "R4 0x10020 not mapped");
    do_q(8, 1'b0, 1'b0, "R4 counter 8 untouched");

    // R10: upper value bits ignored
    do_wr(8, 64'hABC0_0000_0001_0021, 1'b0, "R10 upper bits ignored");
    do_lk(20'h10021, 1'b1, 8, "R10 itlb on 8");

    // R3 zero write to invalid counter changes nothing
    do_wr(1, 64'h0, 1'b1, "R3 zero write to counter 1 rejected");
    do_lk(20'h00001, 1'b1, 5, "R3 cycles kept on 5");

    // R5: remove all mappings of counter 7
    do_wr(7, 64'h0, 1'b0, "R5 clear counter 7");
    do_lk(20'h10019, 1'b0, 0, "R5 dtlb read removed");
    do_lk(20'h1001B, 1'b0, 0, "R5 dtlb write removed");
    do_lk(20'h00001, 1'b1, 5, "R5 cycles kept on 5");
    do_lk(20'h10021, 1'b1, 8, "R5 itlb kept on 8");
    do_wr(9, 64'h10019, 1'b0, "R5 remap dtlb read to 9");
    do_lk(20'h10019, 1'b1, 9, "R5 dtlb read on 9");
    do_wr(5, 64'h0, 1'b0, "R5 clear counter 5");
    do_q(5, 1'b0, 1'b0, "R8 counter 5 no longer cycles");

    // R7: fixed counters
    do_q(0, 1'b1, 1'b0, "R7 counter 0 cycles");
    do_q(2, 1'b0, 1'b1, "R7 counter 2 instructions");
    do_q(1, 1'b0, 1'b0, "R7 counter 1 neither");

    // R9: mask legality
    do_cfg(32'h0000_0001, 1'b1, "R9 bit 0 set");
    do_cfg(32'h0000_0404, 1'b1, "R9 bit 2 set");
    do_cfg(32'hFFFF_FFF8, 1'b0, "R9 full upper mask legal");
    do_cfg(32'hFFFF_FFFF, 1'b1, "R9 all bits set");

    @(negedge clk);
    wr_en = 1'b0;
    #(CLK_PERIOD/2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule